// File: doc/BRIEF.md
# Edge-Selectable Input Capture Timer

This block timestamps edges on a set of pulsed inputs against one shared free-running counter. A prescaler turns the system clock into a one-microsecond tick, and the counter advances once per tick. Each input is synchronized and watched for edges. When an input shows the edge its channel is set to watch, the channel stores the counter value and raises a pending flag. The edge to watch, rising or falling, is chosen per channel. Two channels fed from the same signal can therefore stamp both of its edges.

Each channel also derives two intervals. The first is the period: the distance between its last two captures. The second is the width of the high phase of its own input: the distance from a rising edge to the next falling edge. Both come from modulo subtraction, so they stay correct when the counter wraps.

Software-side logic configures the block through a small write port. One address holds the per-channel edge choice. A second address is write-one-to-clear for the pending flags. A channel that captures again before its flag is cleared keeps the newest value and raises an overrun indication.

Top module: `incap_unit`

## Requirements
- R1: The shared counter is zero after reset and increments by exactly one every TICK_DIV clock cycles, wrapping modulo 2^CNT_W; its value is visible on `now_count`.
- R2: After reset, every capture, period and width value reads zero, and every event and overrun flag is clear.
- R3: A channel whose edge bit is 0 (rising) stores, on a rising edge of its input, the counter value present in the cycle before the capture register loads. That register loads on the third rising clock edge after the input changes (two synchronizer stages plus the capture register).
- R4: A channel whose edge bit is 1 (falling) stores the counter on falling edges only. An edge of the opposite direction changes neither its capture value nor its event flag.
- R5: Two channels driven by the same signal, one set to rising and one to falling, stamp both edges. For a high pulse, the falling stamp minus the rising stamp equals that pulse's measured width.
- R6: Every capture sets the channel's event flag. The flag stays set until a write to address 1 (`reg_sel`=1) with that channel's data bit at 1. Channels whose data bit is 0 are unaffected.
- R7: On each capture after the first, the period output becomes the new capture minus the previous capture, modulo 2^CNT_W. It reads zero until a second capture occurs.
- R8: On each falling input edge that follows a rising input edge, the width output becomes the falling-edge counter value minus the rising-edge counter value, modulo 2^CNT_W. This holds whatever edge the channel captures on.
- R9: A capture that arrives while the event flag is still set sets the overrun flag and replaces the capture value. The overrun flag is cleared by the same clear write as the event flag.
- R10: When a capture and a clear of the same channel happen in the same cycle, the event flag ends up set and the overrun flag ends up clear.
- R11: A write to address 0 (`reg_sel`=0) sets each channel's edge choice from its data bit (bit i for channel i). The choice applies to edges detected after the write and is all-rising after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_CH | Raw pulse inputs, one per channel |
| reg_we | input | 1 | Write strobe of the register port |
| reg_sel | input | 1 | Register address: 0 edge choice, 1 flag clear |
| reg_wdata | input | NUM_CH | Write data, bit i for channel i |
| now_count | output | CNT_W | Shared counter value |
| cap_value | output | NUM_CH*CNT_W | Captured stamps, channel i at bits i*CNT_W upward |
| period_value | output | NUM_CH*CNT_W | Interval between the last two captures per channel |
| width_value | output | NUM_CH*CNT_W | High-phase width per channel |
| event_flag | output | NUM_CH | New capture pending per channel |
| overrun_flag | output | NUM_CH | Capture arrived while pending, per channel |

## Verification
The hardest case to reach from the ports is a capture that lands in exactly the cycle a clear write takes effect. The capture happens only after the input passes through the synchronizer and edge detector. The bench therefore changes an input, counts the known latency, and raises the clear write so that it meets the capture on the same clock edge. Counter wraparound is reached by running with a narrow counter and a two-cycle tick. A long sweep of input patterns then crosses the wrap point many times, at varied gaps and with both edge choices.

// File: rtl/incap_pkg.sv
package incap_pkg;
   // register address decoded from reg_sel
   typedef enum logic {
      REG_EDGE  = 1'b0,
      REG_CLEAR = 1'b1
   } incap_reg_e;

   // per-channel edge choice as held in the edge register
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } incap_edge_e;
endpackage

// File: rtl/incap_timebase.sv
module incap_timebase #(
   parameter int CNT_W    = 32,
   parameter int TICK_DIV = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] count
);
   generate
      if (TICK_DIV == 1) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) count <= '0;
            else        count <= count + 1'b1;
         end
      end else begin : g_divided
         localparam int DW = $clog2(TICK_DIV);
         logic [DW-1:0] div_q;
         logic          tick;
         assign tick = (div_q == DW'(TICK_DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               div_q <= '0;
               count <= '0;
            end else begin
               div_q <= tick ? '0 : div_q + 1'b1;
               if (tick) count <= count + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/incap_chan.sv
module incap_chan #(
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin,
   input  logic             fall_sel,
   input  logic             clr,
   input  logic [CNT_W-1:0] now,
   output logic [CNT_W-1:0] cap,
   output logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] width,
   output logic             evt,
   output logic             ovr,
   output logic             strobe
);
   import incap_pkg::*;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   level, prev_q;
   logic                   rise, fall;
   logic                   have_prev, rise_ok;
   logic [CNT_W-1:0]       rise_ts;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
   end

   assign level  = sync_q[SYNC_STAGES-1];
   assign rise   = level & ~prev_q;
   assign fall   = ~level & prev_q;
   assign strobe = (incap_edge_e'(fall_sel) == EDGE_FALL) ? fall : rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q    <= 1'b0;
         cap       <= '0;
         period    <= '0;
         width     <= '0;
         rise_ts   <= '0;
         have_prev <= 1'b0;
         rise_ok   <= 1'b0;
         evt       <= 1'b0;
         ovr       <= 1'b0;
      end else begin
         prev_q <= level;
         if (strobe) begin
            if (have_prev) period <= now - cap;
            cap       <= now;
            have_prev <= 1'b1;
         end
         if (rise) begin
            rise_ts <= now;
            rise_ok <= 1'b1;
         end
         if (fall && rise_ok) width <= now - rise_ts;
         evt <= (evt & ~clr) | strobe;
         ovr <= (ovr & ~clr) | (strobe & evt & ~clr);
      end
   end
endmodule

// File: rtl/incap_unit.sv
module incap_unit #(
   parameter int NUM_CH      = 4,
   parameter int CNT_W       = 32,
   parameter int TICK_DIV    = 50,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       pin_in,
   input  logic                    reg_we,
   input  logic                    reg_sel,
   input  logic [NUM_CH-1:0]       reg_wdata,
   output logic [CNT_W-1:0]        now_count,
   output logic [NUM_CH*CNT_W-1:0] cap_value,
   output logic [NUM_CH*CNT_W-1:0] period_value,
   output logic [NUM_CH*CNT_W-1:0] width_value,
   output logic [NUM_CH-1:0]       event_flag,
   output logic [NUM_CH-1:0]       overrun_flag
);
   import incap_pkg::*;

   initial begin
      assert (NUM_CH >= 1)      else $error("NUM_CH must be at least 1");
      assert (CNT_W >= 2)       else $error("CNT_W must be at least 2");
      assert (TICK_DIV >= 1)    else $error("TICK_DIV must be at least 1");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_CH-1:0] edge_fall_q;
   logic [NUM_CH-1:0] clr_mask;
   logic [NUM_CH-1:0] cap_strobe;

   always_ff @(posedge clk) begin
      if (!rst_n)
         edge_fall_q <= '0;
      else if (reg_we && incap_reg_e'(reg_sel) == REG_EDGE)
         edge_fall_q <= reg_wdata;
   end

   assign clr_mask = (reg_we && incap_reg_e'(reg_sel) == REG_CLEAR) ? reg_wdata : '0;

   incap_timebase #(
      .CNT_W   (CNT_W),
      .TICK_DIV(TICK_DIV)
   ) u_timebase (
      .clk  (clk),
      .rst_n(rst_n),
      .count(now_count)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         incap_chan #(
            .CNT_W      (CNT_W),
            .SYNC_STAGES(SYNC_STAGES)
         ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (pin_in[i]),
            .fall_sel(edge_fall_q[i]),
            .clr     (clr_mask[i]),
            .now     (now_count),
            .cap     (cap_value[i*CNT_W +: CNT_W]),
            .period  (period_value[i*CNT_W +: CNT_W]),
            .width   (width_value[i*CNT_W +: CNT_W]),
            .evt     (event_flag[i]),
            .ovr     (overrun_flag[i]),
            .strobe  (cap_strobe[i])
         );
      end
   endgenerate
endmodule

// File: rtl/incap_unit_chk.sv
module incap_unit_chk #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [CNT_W-1:0]        now_count,
   input logic [NUM_CH*CNT_W-1:0] cap_value,
   input logic [NUM_CH-1:0]       event_flag,
   input logic [NUM_CH-1:0]       overrun_flag,
   input logic [NUM_CH-1:0]       cap_strobe,
   input logic [NUM_CH-1:0]       clr_mask
);
   assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (now_count == $past(now_count)) || (now_count == CNT_W'($past(now_count) + 1'b1)));

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
         assert_cap_stamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
            cap_strobe[i] |=> cap_value[i*CNT_W +: CNT_W] == $past(now_count));
         assert_cap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_strobe[i] |=> $stable(cap_value[i*CNT_W +: CNT_W]));
         assert_evt_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
            cap_strobe[i] |=> event_flag[i]);
         assert_ovr_with_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
            overrun_flag[i] |-> event_flag[i]);
         assert_ovr_on_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_strobe[i] && event_flag[i] && !clr_mask[i]) |=> overrun_flag[i]);
         assert_clr_meets_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_strobe[i] && clr_mask[i]) |=> (event_flag[i] && !overrun_flag[i]));
      end
   endgenerate
endmodule

bind incap_unit incap_unit_chk #(
   .NUM_CH(NUM_CH),
   .CNT_W (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .now_count   (now_count),
   .cap_value   (cap_value),
   .event_flag  (event_flag),
   .overrun_flag(overrun_flag),
   .cap_strobe  (cap_strobe),
   .clr_mask    (clr_mask)
);

// File: tb/incap_unit_bench.sv
module incap_unit_bench;
   localparam int NCH = 4;
   localparam int W   = 8;
   localparam int DIV = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] pins = '0;
   logic           reg_we = 1'b0;
   logic           reg_sel = 1'b0;
   logic [NCH-1:0] reg_wdata = '0;
   logic [W-1:0]       now_count;
   logic [NCH*W-1:0]   cap_value, period_value, width_value;
   logic [NCH-1:0]     event_flag, overrun_flag;

   int n_cmp = 0;
   int n_bad = 0;

   // bench model of the specification
   logic [NCH-1:0] m_sel = '0;
   logic [NCH-1:0] m_evt = '0, m_ovr = '0, m_have = '0, m_rok = '0;
   logic [W-1:0]   m_cap [NCH];
   logic [W-1:0]   m_per [NCH];
   logic [W-1:0]   m_wid [NCH];
   logic [W-1:0]   m_rts [NCH];

   always #10 clk = ~clk;

   incap_unit #(
      .NUM_CH  (NCH),
      .CNT_W   (W),
      .TICK_DIV(DIV)
   ) u_incap_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_in      (pins),
      .reg_we      (reg_we),
      .reg_sel     (reg_sel),
      .reg_wdata   (reg_wdata),
      .now_count   (now_count),
      .cap_value   (cap_value),
      .period_value(period_value),
      .width_value (width_value),
      .event_flag  (event_flag),
      .overrun_flag(overrun_flag)
   );

   task automatic check(input string tag, input int ch, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s ch%0d: actual %0d expected %0d", tag, ch, act, exp);
      end
   endtask

   task automatic check_all(input string evt_tag);
      for (int c = 0; c < NCH; c++) begin
         check(m_sel[c] ? "R4 capture" : "R3 capture", c, int'(cap_value[c*W +: W]), int'(m_cap[c]));
         check("R7 period", c, int'(period_value[c*W +: W]), int'(m_per[c]));
         check("R8 width", c, int'(width_value[c*W +: W]), int'(m_wid[c]));
         check(evt_tag, c, int'(event_flag[c]), int'(m_evt[c]));
         check("R9 overrun", c, int'(overrun_flag[c]), int'(m_ovr[c]));
      end
   endtask

   task automatic reg_write(input logic sel, input logic [NCH-1:0] data);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
      @(negedge clk);
      reg_we = 1'b0;
      if (sel) begin
         m_evt &= ~data;
         m_ovr &= ~data;
      end else begin
         m_sel = data;
      end
   endtask

   // change the inputs at a negedge; optionally clear flags in the capture cycle
   task automatic drive(input logic [NCH-1:0] nv, input logic [NCH-1:0] clr);
      logic [NCH-1:0] rs, fl, hit;
      logic [W-1:0]   stamp;
      rs = nv & ~pins;
      fl = ~nv & pins;
      pins = nv;
      @(negedge clk);
      @(negedge clk);
      stamp = now_count;
      if (clr != '0) begin
         reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = clr;
      end
      @(negedge clk);
      reg_we = 1'b0;
      for (int c = 0; c < NCH; c++) begin
         hit[c] = m_sel[c] ? fl[c] : rs[c];
         m_ovr[c] = (m_ovr[c] & ~clr[c]) | (hit[c] & m_evt[c] & ~clr[c]);
         m_evt[c] = (m_evt[c] & ~clr[c]) | hit[c];
         if (hit[c]) begin
            if (m_have[c]) m_per[c] = stamp - m_cap[c];
            m_cap[c]  = stamp;
            m_have[c] = 1'b1;
         end
         if (rs[c]) begin
            m_rts[c] = stamp;
            m_rok[c] = 1'b1;
         end
         if (fl[c] && m_rok[c]) m_wid[c] = stamp - m_rts[c];
      end
      check_all((clr & hit) != '0 ? "R10 event" : "R6 event");
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      logic [W-1:0] h1, h2;
      logic [NCH-1:0] v;
      for (int c = 0; c < NCH; c++) begin
         m_cap[c] = '0; m_per[c] = '0; m_wid[c] = '0; m_rts[c] = '0;
      end
      idle(3);
      // R2: reset state
      check("R2 counter", 0, int'(now_count), 0);
      check("R2 caps", 0, int'(cap_value), 0);
      check("R2 periods", 0, int'(period_value), 0);
      check("R2 widths", 0, int'(width_value), 0);
      check("R2 flags", 0, int'({event_flag, overrun_flag}), 0);
      rst_n = 1'b1;

      // R1: step of one every DIV cycles across several wraps
      @(negedge clk); h2 = now_count;
      @(negedge clk); h1 = now_count;
      for (int k = 0; k < 1200; k++) begin
         @(negedge clk);
         if (W'(now_count - h2) != W'(1)) check("R1 counter step", 0, int'(now_count), int'(W'(h2 + 1'b1)));
         else n_cmp++;
         h2 = h1; h1 = now_count;
      end

      // R11: default all-rising; ch2 sees a rise and a fall
      drive(4'b0100, '0);
      drive(4'b0000, '0);
      check("R11 default rising", 2, int'(cap_value[2*W +: W]), int'(m_cap[2]));
      reg_write(1'b1, 4'hF);
      check_all("R6 cleared");
      reg_write(1'b0, 4'b1010);

      // sweep: ch0 and ch1 share one signal, ch2/ch3 independent
      for (int k = 0; k < 160; k++) begin
         v = pins ^ NCH'((k * 5 + 3) % 16);
         v[1] = v[0];
         drive(v, (k % 9 == 4) ? NCH'(k % 16) : '0);
         if (k % 6 == 2) begin
            reg_write(1'b1, NCH'((k * 3) % 16));
            check_all("R6 partial clear");
         end
         if (k == 80) reg_write(1'b0, 4'b0110);
         idle(k % 11);
      end

      // R10: capture meets clear on the same edge, after a pending flag
      reg_write(1'b0, 4'b0010);
      drive({pins[3:2], 2'b00}, '0);
      drive({pins[3:2], 2'b11}, '0);
      drive({pins[3:2], 2'b00}, 4'b0011);
      check("R10 evt kept", 1, int'(event_flag[1]), 1);
      check("R10 ovr clear", 1, int'(overrun_flag[1]), 0);

      // R5: shared signal, rising on ch0 and falling on ch1
      idle(7);
      drive({pins[3:2], 2'b11}, '0);
      idle(13);
      drive({pins[3:2], 2'b00}, '0);
      check("R5 both edges", 1,
            int'(W'(cap_value[1*W +: W] - cap_value[0*W +: W])), int'(width_value[0*W +: W]));
      check("R5 width", 0, int'(width_value[0*W +: W]), int'(m_wid[0]));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule